// File: doc/BRIEF.md
# Sector Burst Reader

This block drains write data from a user-side FIFO whose read data appears one cycle after the read strobe. It moves data in whole 512-byte sectors: each sector is one gapless burst of 32 reads of 128 bits. The forwarded words go to an internal data buffer as a stream with a valid strobe and a last-beat flag.

A transfer begins with a one-cycle `start` pulse that carries the length in sectors. The block starts a burst only when the FIFO count shows at least one whole sector, and only when the downstream side is ready. It repeats bursts until the requested number of sectors has moved, then pulses `done`. A shortage in the FIFO causes a pause, not an error. A zero length finishes at once.

Top module: `brst_fifo_reader`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `fifo_rd_en`, `out_valid`, `out_last` and `done` are low.
- R2: A burst begins, seen as a rise of `fifo_rd_en`, only if bits [15:5] of `fifo_rd_cnt` were non-zero in the cycle before. A count below 32 never starts a read.
- R3: Every burst holds `fifo_rd_en` high for exactly 32 consecutive cycles and then drops it.
- R4: `out_valid` equals `fifo_rd_en` delayed by one cycle. In each valid cycle, `out_data` carries the FIFO word fetched by the previous read, so words leave in FIFO order.
- R5: `out_last` is high together with `out_valid` on the 32nd beat of each burst, and at no other time.
- R6: A transfer of N sectors performs exactly N bursts (32·N beats). After the last beat, `done` is high for one cycle.
- R7: While the FIFO holds less than one sector, the transfer waits with no reads and no `done`. It resumes once the count reaches a whole sector.
- R8: When `ds_ready` is low, no new burst starts. A burst already under way runs to its 32nd read regardless of `ds_ready`.
- R9: A `start` with `len_sectors` equal to zero produces `done` in the next cycle and no reads.
- R10: A `start` pulse while a transfer is in progress is ignored. It changes neither the length nor the number of bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transfer |
| len_sectors | input | 48 | Transfer length in 512-byte sectors, sampled with `start` |
| ds_ready | input | 1 | Downstream may accept another burst |
| fifo_rd_cnt | input | 16 | Number of words held in the user FIFO |
| fifo_rd_en | output | 1 | FIFO read strobe |
| fifo_rd_data | input | 128 | FIFO read word, valid one cycle after the strobe |
| out_valid | output | 1 | Output word valid |
| out_data | output | 128 | Output word |
| out_last | output | 1 | Final beat of a burst |
| done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
The bench targets a FIFO stuck at 31 words. A design that looked at the low count bits would read into an empty FIFO and return garbage. It also drops `ds_ready` in the middle of a burst; a design that cut the burst short would leave 32-beat framing misaligned, and `out_last` would land on the wrong word. A `start` pulse arrives during a transfer; a design that reloaded the length would over-read the FIFO and steal words that belong to later transfers. The bench also sweeps lengths of 1 to 8 sectors with the FIFO fed in uneven chunks. This exposes off-by-one burst counts, which show up as a `done` pulse that comes early or late against the beat total, and it covers the zero-length case, which would hang.

// File: rtl/brst_pkg.sv
package brst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } brst_state_t;
endpackage

// File: rtl/brst_sector_ctr.sv
module brst_sector_ctr #(
  parameter int LEN_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [LEN_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (dec && (remain_q != '0)) begin
      remain_q <= remain_q - LEN_W'(1);
    end
  end

  assign zero = (remain_q == '0);
endmodule

// File: rtl/brst_beat_ctr.sv
module brst_beat_ctr #(
  parameter int BEATS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic rd_en,
  output logic final_beat
);
  localparam int BEAT_LOG = $clog2(BEATS);
  localparam logic [BEAT_LOG-1:0] BEAT_MAX = BEAT_LOG'(BEATS - 1);

  logic [BEAT_LOG-1:0] beat_q;
  logic                en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      beat_q <= '0;
    end else if (go && !en_q) begin
      en_q   <= 1'b1;
      beat_q <= '0;
    end else if (en_q) begin
      if (beat_q == BEAT_MAX) begin
        en_q <= 1'b0;
      end
      beat_q <= beat_q + BEAT_LOG'(1);
    end
  end

  assign rd_en      = en_q;
  assign final_beat = en_q && (beat_q == BEAT_MAX);
endmodule

// File: rtl/brst_out_stage.sv
module brst_out_stage #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              final_beat,
  input  logic [DATA_W-1:0] rd_data,
  output logic              out_valid,
  output logic              out_last,
  output logic [DATA_W-1:0] out_data
);
  logic valid_q;
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      valid_q <= rd_en;
      last_q  <= final_beat;
    end
  end

  // The FIFO already registers its data, so the word lines up with valid_q.
  assign out_valid = valid_q;
  assign out_last  = last_q;
  assign out_data  = rd_data;
endmodule

// File: rtl/brst_fifo_reader.sv
module brst_fifo_reader
  import brst_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 48,
  parameter int BEATS  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_sectors,
  input  logic              ds_ready,
  input  logic [CNT_W-1:0]  fifo_rd_cnt,
  output logic              fifo_rd_en,
  input  logic [DATA_W-1:0] fifo_rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              done
);
  localparam int BEAT_LOG = $clog2(BEATS);

  brst_state_t state_q;
  logic        done_q;
  logic        load;
  logic        dec;
  logic        zero;
  logic        go;
  logic        final_beat;
  logic        block_ok;

  assign block_ok = |fifo_rd_cnt[CNT_W-1:BEAT_LOG];
  assign load     = (state_q == ST_IDLE) && start && (len_sectors != '0);
  assign go       = (state_q == ST_WAIT) && !zero && block_ok && ds_ready;
  assign dec      = (state_q == ST_RUN) && final_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (len_sectors == '0) done_q <= 1'b1;
            else                   state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (zero) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (go) begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (final_beat) state_q <= ST_WAIT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done = done_q;

  brst_sector_ctr #(.LEN_W(LEN_W)) u_sectors (
    .clk(clk), .rst(rst), .load(load), .load_val(len_sectors),
    .dec(dec), .zero(zero)
  );

  brst_beat_ctr #(.BEATS(BEATS)) u_beats (
    .clk(clk), .rst(rst), .go(go), .rd_en(fifo_rd_en), .final_beat(final_beat)
  );

  brst_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .rd_en(fifo_rd_en), .final_beat(final_beat),
    .rd_data(fifo_rd_data), .out_valid(out_valid), .out_last(out_last),
    .out_data(out_data)
  );
endmodule

// File: rtl/brst_fifo_reader_chk.sv
module brst_fifo_reader_chk #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 48,
  parameter int BEATS  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [LEN_W-1:0]  len_sectors,
  input logic              ds_ready,
  input logic [CNT_W-1:0]  fifo_rd_cnt,
  input logic              fifo_rd_en,
  input logic [DATA_W-1:0] fifo_rd_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              done
);
  localparam int BEAT_LOG = $clog2(BEATS);

  logic [BEAT_LOG:0] run_cnt;
  logic              seen_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      seen_clk <= 1'b0;
    end else begin
      seen_clk <= 1'b1;
      run_cnt  <= fifo_rd_en ? run_cnt + (BEAT_LOG+1)'(1) : '0;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      assert_reset_quiet_R1: assert (!done && !out_valid)
        else $error("outputs active in reset");
    end
  end

  assert_start_needs_block_R2: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && $rose(fifo_rd_en)) |-> $past(|fifo_rd_cnt[CNT_W-1:BEAT_LOG]));

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && $fell(fifo_rd_en)) |-> (run_cnt == (BEAT_LOG+1)'(BEATS)));

  assert_burst_cap_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_en |-> (run_cnt < (BEAT_LOG+1)'(BEATS)));

  assert_valid_lag_R4: assert property (@(posedge clk) disable iff (rst)
    seen_clk |-> (out_valid == $past(fifo_rd_en)));

  assert_last_in_valid_R5: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!fifo_rd_en && !out_valid));

  assert_ready_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && $rose(fifo_rd_en)) |-> $past(ds_ready));
endmodule

bind brst_fifo_reader brst_fifo_reader_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .BEATS(BEATS)
) u_chk (.*);

// File: tb/test_brst_fifo_reader.sv
module test_brst_fifo_reader;
  localparam int CLK_PERIOD = 10;
  localparam int BEATS      = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [47:0]  len_sectors = '0;
  logic         ds_ready = 1'b1;
  logic [15:0]  fifo_rd_cnt;
  logic         fifo_rd_en;
  logic [127:0] fifo_rd_data;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_last;
  logic         done;

  int errors = 0;
  int checks = 0;
  int pushed = 0;
  int popped = 0;
  int out_idx = 0;
  int done_cnt = 0;
  int run_len = 0;
  logic prev_rd = 1'b0;
  logic prev_blk_ok = 1'b0;
  logic prev_ready = 1'b0;
  logic mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brst_fifo_reader i_brst_fifo_reader (
    .clk(clk), .rst(rst), .start(start), .len_sectors(len_sectors),
    .ds_ready(ds_ready), .fifo_rd_cnt(fifo_rd_cnt), .fifo_rd_en(fifo_rd_en),
    .fifo_rd_data(fifo_rd_data), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .done(done)
  );

  function automatic logic [127:0] pat(input int i);
    return {32'(i) * 32'd3, ~32'(i), 32'(i) + 32'd7, 32'(i)};
  endfunction

  assign fifo_rd_cnt = 16'(pushed - popped);

  // FIFO model: data registered one cycle after the read strobe
  always @(posedge clk) begin
    if (fifo_rd_en) begin
      fifo_rd_data <= pat(popped);
      popped <= popped + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle monitor
  always @(negedge clk) begin
    if (mon_on) begin
      check(out_valid == prev_rd, "R4", "valid lag", out_valid, prev_rd);
      if (fifo_rd_en && !prev_rd) begin
        check(prev_blk_ok, "R2", "burst start with short count", 0, 1);
        check(prev_ready, "R8", "burst start with ready low", 0, 1);
      end
      if (fifo_rd_en) run_len++;
      else if (prev_rd) begin
        check(run_len == BEATS, "R3", "read run length", run_len, BEATS);
        run_len = 0;
      end
      if (out_valid) begin
        check(out_data == pat(out_idx), "R4", "data word index", out_idx, out_idx);
        check(out_last == ((out_idx % BEATS) == BEATS-1), "R5", "last flag",
              out_last, (out_idx % BEATS) == BEATS-1);
        out_idx++;
      end else begin
        check(!out_last, "R5", "last without valid", out_last, 0);
      end
      if (done) done_cnt++;
    end
    prev_rd     = fifo_rd_en;
    prev_blk_ok = (fifo_rd_cnt >= 16'd32);
    prev_ready  = ds_ready;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int n);
    pushed = pushed + n;
  endtask

  task automatic kick(input int len);
    start = 1'b1;
    len_sectors = 48'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int base, input string req);
    int t = 0;
    while (done_cnt == base && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(done_cnt == base + 1, req, "done pulse count", done_cnt, base + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base, beats0;
    cycles(3);
    check(!fifo_rd_en && !out_valid && !out_last && !done, "R1", "outputs in reset",
          {fifo_rd_en, out_valid, out_last, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!fifo_rd_en && !out_valid && !out_last && !done, "R1", "outputs after reset",
          {fifo_rd_en, out_valid, out_last, done}, 0);
    mon_on = 1'b1;

    // R9: zero length
    base = done_cnt;
    start = 1'b1; len_sectors = '0;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R9", "done one cycle after zero start", done, 1);
    check(!fifo_rd_en, "R9", "no read on zero length", fifo_rd_en, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done single cycle", done, 0);
    check(popped == 0, "R9", "words read", popped, 0);

    // R2/R7: 31 words then the 32nd
    push(31);
    base = done_cnt;
    kick(1);
    cycles(60);
    check(popped == 0, "R2", "reads with 31 words", popped, 0);
    check(done_cnt == base, "R7", "done while paused", done_cnt, base);
    push(1);
    wait_done(base, "R7");
    check(out_idx == 32, "R6", "beats for one sector", out_idx, 32);

    // R8: ready low blocks start, not a running burst
    ds_ready = 1'b0;
    push(64);
    base = done_cnt;
    kick(2);
    cycles(20);
    check(popped == 32, "R8", "reads while ready low", popped, 32);
    ds_ready = 1'b1;
    while (!fifo_rd_en) @(negedge clk);
    cycles(4);
    ds_ready = 1'b0;
    cycles(80);
    check(popped == 64, "R8", "burst finished after ready drop", popped, 64);
    ds_ready = 1'b1;
    wait_done(base, "R8");
    check(out_idx == 96, "R6", "beats for two sectors", out_idx, 96);

    // R10: start during transfer ignored
    push(96);
    base = done_cnt;
    kick(3);
    cycles(5);
    kick(5);
    wait_done(base, "R10");
    cycles(100);
    check(out_idx == 192, "R10", "beats after ignored start", out_idx, 192);
    check(popped == pushed, "R10", "FIFO level after transfer", pushed - popped, 0);
    check(done_cnt == base + 1, "R10", "extra done", done_cnt, base + 1);

    // Sweep: lengths 1..8 with FIFO fed in chunks of 17
    for (int len = 1; len <= 8; len++) begin
      base = done_cnt;
      beats0 = out_idx;
      kick(len);
      while (done_cnt == base && popped < 40000) begin
        if (pushed - (beats0 + 32*len) < 17 && (pushed - popped) < 40) push(17);
        cycles(3);
      end
      check(done_cnt == base + 1, "R6", "sweep done pulse", done_cnt, base + 1);
      check(out_idx - beats0 == 32*len, "R6", "sweep beat count",
            out_idx - beats0, 32*len);
    end

    cycles(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule